// File: doc/BRIEF.md
# Converter Back-End Self-Test Engine

This block is a self-test engine for the digital back end of a data converter. In normal operation each encode-qualified sample passes through a small processing stage and appears on the output. That stage applies a saturating twos complement offset and then selects either offset binary or twos complement output. When the test mode is armed through the control register, the engine replaces the samples with a pseudorandom word stream. It then folds every processed word into a 16-bit signature register for a fixed number of encode cycles.

The offset and format stages sit in front of the signature stage, so every configuration has its own signature. The same configuration always gives the same value. Software compares the signature with one recorded on a known-good part. An optional pre-clear allows several runs to be chained into one signature. The mode field clears itself when a run ends, and a done flag reports the completion.

Top module: `bist_engine`

## Requirements
- R1: After reset, every register reads 0x00, `data_o` is 0x0000 and `done_o` is low.
- R2: The register map is: address 0 control, 1 offset, 2 format, 3 signature low byte, 4 signature high byte. Control bits [7:3] always read 0 and writes to them are ignored. Control bit 2 is the init flag and bits [1:0] are the mode. Format bit 0 selects twos complement output (1) or offset binary output (0), and format bits [7:1] read 0.
- R3: Outside a test run, on every clock edge with `enc_en_i` high, `data_o` takes the twos complement sample plus the sign-extended 8-bit offset (0x01 = +1, 0xFF = -1). In offset binary format the result has its MSB inverted.
- R4: The offset addition saturates: results above 0x7FFF give 0x7FFF, and results below 0x8000 (as signed) give 0x8000, before the format stage.
- R5: Writing mode 01 starts a run. The stimulus is a 16-bit Fibonacci LFSR seeded to 0xACE1. Its next state is {s[14:0], s[15]^s[14]^s[12]^s[3]}. On each counted encode cycle the signature becomes {g[14:0], g[15]^g[14]^g[12]^g[3]} XOR w, where g is the old signature and w is the processed LFSR word, and the LFSR then advances. `sample_i` has no effect on the signature.
- R6: A run absorbs exactly 256 encode cycles. Clock cycles with `enc_en_i` low do not count, and encode cycles after the run ends do not change the signature.
- R7: When a run completes, the mode field returns to 00 and `done_o` goes high. The init flag keeps its value.
- R8: With init = 1 the signature is cleared when the run starts. With init = 0 the previous signature is kept as the starting value, so runs accumulate.
- R9: Modes 10 and 11 behave as 00: the signature is unchanged and samples follow the normal path.
- R10: A control write that starts a run clears `done_o`. A start written while a run is in progress restarts the count, reseeds the LFSR and applies the init flag again. A control write in the same cycle as an encode pulse takes precedence, and that encode cycle is not counted.
- R11: The signature is read as two bytes: address 3 returns bits [7:0] and address 4 returns bits [15:8].
- R12: The offset and format settings change the signature, as described by the model in R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enc_en_i | input | 1 | Encode-cycle qualifier |
| sample_i | input | 16 | Converter sample, twos complement |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational from address |
| data_o | output | 16 | Processed output word |
| done_o | output | 1 | Run complete flag |

## Verification
The assertions assume that reset is asserted from time zero and that writes and encode pulses carry known values once reset is released. They also assume that `enc_en_i` may be high on any clock, including the cycle of a control write. The stimulus changes every input on the falling edge only and never leaves the sample or write data unknown. It places some control writes right after long encode bursts and with gaps between encode pulses, so both the priority rule and the gaps are exercised.

// File: rtl/bist_pkg.sv
package bist_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned REG_W  = 8;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_OFFS   = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_FMT    = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_SIG_LO = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_SIG_HI = 3'd4;

  localparam logic [1:0] MODE_OFF  = 2'b00;
  localparam logic [1:0] MODE_PRBS = 2'b01;

  // feedback taps 16,15,13,4 -> bits 15,14,12,3
  localparam logic [WORD_W-1:0] POLY_MASK = 16'hD008;

  function automatic logic [WORD_W-1:0] shift_fb(input logic [WORD_W-1:0] s,
                                                 input logic [WORD_W-1:0] mask);
    return {s[WORD_W-2:0], ^(s & mask)};
  endfunction
endpackage

// File: rtl/bist_prbs.sv
module bist_prbs #(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] SEED = 16'hACE1,
  parameter logic [W-1:0] MASK = 16'hD008
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         step_i,
  output logic [W-1:0] state_o
);
  logic [W-1:0] state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= SEED;
    else if (load_i) state_q <= SEED;
    else if (step_i) state_q <= {state_q[W-2:0], ^(state_q & MASK)};
  end

  assign state_o = state_q;

  assert_lfsr_live_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0);
endmodule

// File: rtl/bist_datapath.sv
module bist_datapath #(
  parameter int unsigned W     = 16,
  parameter int unsigned OFF_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [W-1:0]     in_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic             twos_i,
  output logic [W-1:0]     word_o,
  output logic [W-1:0]     data_o
);
  localparam int unsigned SUM_W = W + 1;
  localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_MAX = {1'b1, {(W-1){1'b0}}};

  logic [SUM_W-1:0] sum;
  logic [W-1:0]     sat;
  logic [W-1:0]     data_q;

  assign sum = {in_i[W-1], in_i} + {{(SUM_W-OFF_W){off_i[OFF_W-1]}}, off_i};

  always_comb begin
    if (sum[SUM_W-1] != sum[SUM_W-2]) sat = sum[SUM_W-1] ? NEG_MAX : POS_MAX;
    else                              sat = sum[W-1:0];
  end

  assign word_o = twos_i ? sat : {~sat[W-1], sat[W-2:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   data_q <= '0;
    else if (en_i) data_q <= word_o;
  end

  assign data_o = data_q;

  // saturation must never wrap past the input
  assert_sat_up_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !off_i[OFF_W-1] |-> $signed(sat) >= $signed(in_i));
  assert_sat_dn_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_i[OFF_W-1] |-> $signed(sat) <= $signed(in_i));
endmodule

// File: rtl/bist_misr.sv
module bist_misr #(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] MASK = 16'hD008
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         upd_i,
  input  logic [W-1:0] word_i,
  output logic [W-1:0] sig_o
);
  logic [W-1:0] sig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sig_q <= '0;
    else if (clr_i)  sig_q <= '0;
    else if (upd_i)  sig_q <= {sig_q[W-2:0], ^(sig_q & MASK)} ^ word_i;
  end

  assign sig_o = sig_q;

  assert_sig_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd_i && !clr_i) |=> $stable(sig_q));
  assert_sig_clr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> sig_q == '0);
endmodule

// File: rtl/bist_ctrl.sv
module bist_ctrl
  import bist_pkg::*;
#(
  parameter int unsigned RUN_LEN = 256,
  parameter int unsigned OFF_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enc_en_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic [WORD_W-1:0] sig_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic [OFF_W-1:0]  off_o,
  output logic              twos_o,
  output logic              active_o,
  output logic              start_o,
  output logic              clr_o,
  output logic              step_o,
  output logic              done_o
);
  localparam int unsigned CNT_W = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RUN_LEN - 1);

  logic [1:0]       mode_q;
  logic             init_q;
  logic             done_q;
  logic             twos_q;
  logic [OFF_W-1:0] off_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ctrl_wr, last;

  assign ctrl_wr  = we_i && (addr_i == ADDR_CTRL);
  assign start_o  = ctrl_wr && (wdata_i[1:0] == MODE_PRBS);
  assign clr_o    = start_o && wdata_i[2];
  assign active_o = (mode_q == MODE_PRBS);
  assign step_o   = active_o && enc_en_i && !ctrl_wr;
  assign last     = step_o && (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_OFF;
      init_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else if (ctrl_wr) begin
      mode_q <= wdata_i[1:0];
      init_q <= wdata_i[2];
      cnt_q  <= '0;
      if (start_o) done_q <= 1'b0;
    end else if (last) begin
      mode_q <= MODE_OFF;
      done_q <= 1'b1;
      cnt_q  <= '0;
    end else if (step_o) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q  <= '0;
      twos_q <= 1'b0;
    end else if (we_i) begin
      if (addr_i == ADDR_OFFS) off_q  <= wdata_i[OFF_W-1:0];
      if (addr_i == ADDR_FMT)  twos_q <= wdata_i[0];
    end
  end

  always_comb begin
    case (addr_i)
      ADDR_CTRL:   rdata_o = {5'b0, init_q, mode_q};
      ADDR_OFFS:   rdata_o = REG_W'(off_q);
      ADDR_FMT:    rdata_o = {7'b0, twos_q};
      ADDR_SIG_LO: rdata_o = sig_i[7:0];
      ADDR_SIG_HI: rdata_o = sig_i[15:8];
      default:     rdata_o = '0;
    endcase
  end

  assign off_o  = off_q;
  assign twos_o = twos_q;
  assign done_o = done_q;

  assert_run_end_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last |=> (mode_q == MODE_OFF) && done_q);
  assert_start_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !done_q && (cnt_q == '0) && (mode_q == MODE_PRBS));
  assert_rsvd_mode_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q[1] && !ctrl_wr) |=> $stable(cnt_q) && (mode_q[1] || done_q == $past(done_q)));
  assert_done_src_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> $past(active_o));
endmodule

// File: rtl/bist_engine.sv
module bist_engine
  import bist_pkg::*;
#(
  parameter int unsigned RUN_LEN = 256,
  parameter logic [WORD_W-1:0] SEED = 16'hACE1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enc_en_i,
  input  logic [WORD_W-1:0] sample_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic [WORD_W-1:0] data_o,
  output logic              done_o
);
  localparam int unsigned OFF_W = REG_W;

  logic [OFF_W-1:0]  off;
  logic              twos, active, start, clr, step;
  logic [WORD_W-1:0] lfsr, src, word, sig;

  bist_ctrl #(.RUN_LEN(RUN_LEN), .OFF_W(OFF_W)) u_ctrl (
    .clk_i, .rst_ni, .enc_en_i,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .sig_i(sig), .rdata_o(reg_rdata_o), .off_o(off), .twos_o(twos),
    .active_o(active), .start_o(start), .clr_o(clr), .step_o(step),
    .done_o(done_o)
  );

  bist_prbs #(.W(WORD_W), .SEED(SEED), .MASK(POLY_MASK)) u_prbs (
    .clk_i, .rst_ni, .load_i(start), .step_i(step), .state_o(lfsr)
  );

  assign src = active ? lfsr : sample_i;

  bist_datapath #(.W(WORD_W), .OFF_W(OFF_W)) u_dp (
    .clk_i, .rst_ni, .en_i(enc_en_i), .in_i(src), .off_i(off),
    .twos_i(twos), .word_o(word), .data_o(data_o)
  );

  bist_misr #(.W(WORD_W), .MASK(POLY_MASK)) u_misr (
    .clk_i, .rst_ni, .clr_i(clr), .upd_i(step), .word_i(word), .sig_o(sig)
  );
endmodule

// File: tb/tb_bist_engine.sv
`timescale 1ns/1ps
module tb_bist_engine;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        enc_en_i = 1'b0;
  logic [15:0] sample_i = '0;
  logic        reg_we_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [7:0]  reg_wdata_i = '0;
  logic [7:0]  reg_rdata_o;
  logic [15:0] data_o;
  logic        done_o;

  int n_chk = 0;
  int n_bad = 0;

  bist_engine dut (.*);

  always #2.5 clk_i = ~clk_i;

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog: act=hung exp=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] fb(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[14] ^ s[12] ^ s[3]};
  endfunction

  function automatic logic [15:0] proc(input logic [15:0] s, input logic [7:0] off, input bit twos);
    int v;
    logic [15:0] r;
    v = $signed(s) + $signed(off);
    if (v > 32767) v = 32767;
    if (v < -32768) v = -32768;
    r = 16'(v);
    return twos ? r : (r ^ 16'h8000);
  endfunction

  function automatic logic [15:0] model(input logic [15:0] prev, input logic [7:0] off, input bit twos);
    logic [15:0] s = 16'hACE1;
    logic [15:0] g = prev;
    for (int i = 0; i < 256; i++) begin
      g = fb(g) ^ proc(s, off, twos);
      s = fb(s);
    end
    return g;
  endfunction

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic rd_sig(output logic [15:0] s);
    logic [7:0] lo, hi;
    rd(3'd3, lo);
    rd(3'd4, hi);
    s = {hi, lo};
  endtask

  task automatic enc(input int n);
    @(negedge clk_i);
    enc_en_i = 1'b1;
    repeat (n) @(negedge clk_i);
    enc_en_i = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), d);
      chk("R1 reg reset", {8'h0, d}, 16'h0);
    end
    chk("R1 data_o reset", data_o, 16'h0);
    chk("R1 done reset", {15'h0, done_o}, 16'h0);
  endtask

  task automatic t_rsvd();
    logic [7:0] d;
    wr(3'd0, 8'hF8);
    rd(3'd0, d); chk("R2 ctrl rsvd", {8'h0, d}, 16'h0000);
    wr(3'd0, 8'hFC);
    rd(3'd0, d); chk("R2 ctrl init only", {8'h0, d}, 16'h0004);
    wr(3'd2, 8'hFF);
    rd(3'd2, d); chk("R2 fmt rsvd", {8'h0, d}, 16'h0001);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_normal();
    wr(3'd1, 8'h00); wr(3'd2, 8'h01);
    sample_i = 16'h1234; enc(1);
    chk("R3 twos off0", data_o, 16'h1234);
    wr(3'd1, 8'hFF);
    sample_i = 16'h1234; enc(1);
    chk("R3 twos off-1", data_o, 16'h1233);
    wr(3'd2, 8'h00);
    enc(1);
    chk("R3 offset binary", data_o, 16'h9233);
    sample_i = 16'h5555; @(negedge clk_i); @(negedge clk_i);
    chk("R3 no enc hold", data_o, 16'h9233);
  endtask

  task automatic t_sat();
    wr(3'd2, 8'h01);
    wr(3'd1, 8'h7F); sample_i = 16'h7FF0; enc(1);
    chk("R4 pos sat", data_o, 16'h7FFF);
    wr(3'd1, 8'h80); sample_i = 16'h8005; enc(1);
    chk("R4 neg sat", data_o, 16'h8000);
  endtask

  task automatic t_run(output logic [15:0] s1);
    logic [7:0] d;
    logic [15:0] exp;
    wr(3'd1, 8'h05); wr(3'd2, 8'h01);
    exp = model(16'h0, 8'h05, 1'b1);
    sample_i = 16'h0F0F;
    wr(3'd0, 8'h05);
    rd(3'd0, d); chk("R5 mode armed", {8'h0, d}, 16'h0005);
    chk("R10 done low in run", {15'h0, done_o}, 16'h0);
    enc(256);
    rd_sig(s1);
    chk("R5 R11 signature", s1, exp);
    chk("R7 done set", {15'h0, done_o}, 16'h1);
    rd(3'd0, d); chk("R7 mode cleared", {8'h0, d}, 16'h0004);
    enc(10);
    rd_sig(s1);
    chk("R6 post-run stable", s1, exp);
    sample_i = 16'hA5A5;
    wr(3'd0, 8'h05);
    enc(100); repeat (40) @(negedge clk_i); enc(156);
    rd_sig(s1);
    chk("R5 R6 sample ignored, gaps", s1, exp);
  endtask

  task automatic t_chain(input logic [15:0] s1);
    logic [15:0] s;
    wr(3'd0, 8'h01);
    enc(256);
    rd_sig(s);
    chk("R8 chained", s, model(s1, 8'h05, 1'b1));
    wr(3'd0, 8'h05);
    enc(256);
    rd_sig(s);
    chk("R8 init clears", s, s1);
  endtask

  task automatic t_rsvd_mode(input logic [15:0] s1);
    logic [15:0] s;
    wr(3'd0, 8'h06);
    sample_i = 16'h0100; enc(300);
    rd_sig(s);
    chk("R9 mode10 sig hold", s, s1);
    chk("R9 mode10 data normal", data_o, 16'h0105);
    chk("R9 done untouched", {15'h0, done_o}, 16'h1);
    wr(3'd0, 8'h03); enc(20);
    rd_sig(s);
    chk("R9 mode11 sig hold", s, s1);
  endtask

  task automatic t_restart(input logic [15:0] s1);
    logic [15:0] s;
    wr(3'd0, 8'h05);
    chk("R10 done cleared", {15'h0, done_o}, 16'h0);
    enc(100);
    // start written while encode stays high: that cycle not counted
    @(negedge clk_i);
    enc_en_i = 1'b1; reg_we_i = 1'b1; reg_addr_i = 3'd0; reg_wdata_i = 8'h05;
    @(negedge clk_i);
    reg_we_i = 1'b0;
    repeat (255) @(negedge clk_i);
    chk("R10 not done at 255", {15'h0, done_o}, 16'h0);
    @(negedge clk_i);
    enc_en_i = 1'b0;
    rd_sig(s);
    chk("R10 restart signature", s, s1);
    chk("R10 done after restart", {15'h0, done_o}, 16'h1);
  endtask

  task automatic t_cfg(input logic [15:0] s1);
    logic [15:0] s, exp;
    wr(3'd1, 8'h80); wr(3'd2, 8'h00);
    exp = model(16'h0, 8'h80, 1'b0);
    wr(3'd0, 8'h05);
    enc(256);
    rd_sig(s);
    chk("R12 config signature", s, exp);
    n_chk++;
    if (s == s1) begin
      n_bad++;
      $display("FAIL R12 signature unchanged: act=%h exp!=%h", s, s1);
    end
  endtask

  initial begin
    logic [15:0] s1;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_rsvd();
    t_normal();
    t_sat();
    t_run(s1);
    t_chain(s1);
    t_rsvd_mode(s1);
    t_restart(s1);
    t_cfg(s1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule